// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block follows a chain of block descriptors kept in memory on behalf of one DMA channel. Software, or a channel controller, hands it the pointer to the first descriptor and pulses start. The walker reads the descriptor one word at a time over a plain request/response memory port. It holds the words in channel registers and presents the block to a separate data-moving engine. When the engine reports the block finished, the walker writes the updated status words back into the descriptor. It then either moves on to the next descriptor or returns to idle.

A descriptor is seven little-endian 32-bit words, at word offsets 0 to 6: source address, destination address, next pointer, control low, control high, source status and destination status. Only the first five words are fetched. Only the last three are written back. The two low bits of any descriptor pointer choose the bus master that fetches that descriptor. The rest of the pointer, with those two bits cleared, is the descriptor's byte address.

An abort input stops the walk cleanly. A status port shows the phase and the descriptor currently in hand.

Top module: `ll_desc_walker`

## Requirements
- R1: After reset the walker is idle: `st_state_o` is 0, and `mem_req_o` and `blk_valid_o` are low.
- R2: In idle, a start pulse begins a walk. `st_addr_o` becomes the start pointer with bits [1:0] cleared, and `mem_master_o` becomes pointer bits [1:0]. A start pulse while the walker is busy has no effect.
- R3: The fetch phase reads five words at the descriptor address plus 0, 4, 8, 12 and 16, in that order, with `mem_we_o` low. Only one access is outstanding at a time. A request and its address are held until `mem_rsp_i` is seen with the request.
- R4: Once the fifth word is in, `blk_valid_o` stays high until `blk_done_i`. While it is high, the block ports show the fetched values: source at offset 0, destination at offset 4, control low at offset 12, and size taken from bits [11:0] of control high at offset 16.
- R5: After `blk_done_i`, the walker writes three words, with `mem_we_o` high, at offsets 16, 20 and 24. The first word is control high with bits [31:13] kept, bit 12 set to 1 and bits [11:0] replaced by `blk_count_i`. The second and third words are `blk_sstat_i` and `blk_dstat_i`, sampled at `blk_done_i`.
- R6: After write-back, the walker follows the chain only if control-low bit 28 (source chaining) or bit 27 (destination chaining) is set. It then fetches from the next-pointer word with bits [1:0] cleared, using master select equal to next-pointer bits [1:0]. If neither bit is set, it returns to idle.
- R7: A next pointer whose address part (bits [31:2]) is zero ends the chain even when a chaining bit is set.
- R8: An abort raised during fetch or write-back lets the access in flight complete. After that response the walker returns to idle and issues no further access, so no write-back follows.
- R9: An abort raised while a block is running returns the walker to idle on the next cycle, without any write-back.
- R10: `st_state_o` encodes the phase as 0 idle, 1 fetching, 2 running, 3 writing back. `st_addr_o` shows the byte address of the current descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a walk (sampled in idle only) |
| start_ptr_i | input | 32 | First descriptor pointer, master select in [1:0] |
| abort_i | input | 1 | Abort request |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_master_o | output | 2 | Bus master select for the access |
| mem_rsp_i | input | 1 | Access complete (read data valid) |
| mem_rdata_i | input | 32 | Read data |
| blk_valid_o | output | 1 | Block presented to the engine |
| blk_sar_o | output | 32 | Block source address |
| blk_dar_o | output | 32 | Block destination address |
| blk_ctl_lo_o | output | 32 | Block control-low word |
| blk_size_o | output | 12 | Block transfer size |
| blk_done_i | input | 1 | Engine finished the block |
| blk_count_i | input | 12 | Items transferred, for write-back |
| blk_sstat_i | input | 32 | Source status for write-back |
| blk_dstat_i | input | 32 | Destination status for write-back |
| st_state_o | output | 2 | Phase code |
| st_addr_o | output | 32 | Current descriptor address |

## Verification
Every output of the walker comes from a register. A response, done pulse, start or abort sampled on a rising edge therefore shows its effect on the ports just after that same edge. The new phase, the next address and the next write word are all due one cycle after the stimulus. The bench drives inputs shortly after each rising edge. A behavioural model advances on the same rising edge, and every output is compared against that model at the following falling edge. The bench also checks the descriptor memory after each walk, for done flags and counts and for untouched words after an abort. It varies memory latency so that back-to-back responses and held requests are both covered.

// File: rtl/lw_pkg.sv
package lw_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2,
    ST_WB    = 2'd3
  } walk_st_e;

  // fetched word slots
  localparam int unsigned N_FETCH   = 5;
  localparam int unsigned W_SRC     = 0;
  localparam int unsigned W_DST     = 1;
  localparam int unsigned W_NEXT    = 2;
  localparam int unsigned W_CTLLO   = 3;
  localparam int unsigned W_CTLHI   = 4;

  localparam logic [2:0] LAST_FETCH_IDX = 3'(N_FETCH - 1);
  localparam logic [2:0] LAST_WB_IDX    = 3'd2;
  localparam logic [WORD_W-1:0] WB_BYTE_OFF = 32'd16;

  localparam int unsigned CL_SRC_CHAIN = 28;
  localparam int unsigned CL_DST_CHAIN = 27;
endpackage

// File: rtl/lw_desc_regs.sv
module lw_desc_regs
  import lw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en_i,
  input  logic [2:0]        ld_idx_i,
  input  logic [WORD_W-1:0] ld_data_i,
  output logic [WORD_W-1:0] src_o,
  output logic [WORD_W-1:0] dst_o,
  output logic [WORD_W-1:0] next_o,
  output logic [WORD_W-1:0] ctl_lo_o,
  output logic [WORD_W-1:0] ctl_hi_o
);
  logic [WORD_W-1:0] word_q [N_FETCH];

  for (genvar g = 0; g < N_FETCH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= '0;
      end else if (ld_en_i && (ld_idx_i == 3'(g))) begin
        word_q[g] <= ld_data_i;
      end
    end
  end

  assign src_o    = word_q[W_SRC];
  assign dst_o    = word_q[W_DST];
  assign next_o   = word_q[W_NEXT];
  assign ctl_lo_o = word_q[W_CTLLO];
  assign ctl_hi_o = word_q[W_CTLHI];
endmodule

// File: rtl/lw_ctrl.sv
module lw_ctrl
  import lw_pkg::*;
#(
  parameter int unsigned SIZE_W = 12
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] start_ptr_i,
  input  logic              abort_i,
  input  logic              mem_ack_i,
  input  logic              blk_done_i,
  input  logic [SIZE_W-1:0] blk_count_i,
  input  logic [WORD_W-1:0] blk_sstat_i,
  input  logic [WORD_W-1:0] blk_dstat_i,
  input  logic [WORD_W-1:0] next_i,
  input  logic              chain_en_i,
  output walk_st_e          st_o,
  output logic [2:0]        idx_o,
  output logic [WORD_W-1:0] base_o,
  output logic [1:0]        master_o,
  output logic              ld_en_o,
  output logic [SIZE_W-1:0] cnt_o,
  output logic [WORD_W-1:0] sstat_o,
  output logic [WORD_W-1:0] dstat_o
);
  walk_st_e          st_q, st_d;
  logic [2:0]        idx_q, idx_d;
  logic [WORD_W-1:0] base_q, base_d;
  logic [1:0]        mst_q, mst_d;
  logic              abp_q, abp_d;
  logic              res_en;
  logic              stop_now;
  logic              follow;

  logic [SIZE_W-1:0] cnt_q;
  logic [WORD_W-1:0] sstat_q, dstat_q;

  assign stop_now = abp_q | abort_i;
  assign follow   = chain_en_i && (next_i[WORD_W-1:2] != '0);

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    base_d  = base_q;
    mst_d   = mst_q;
    abp_d   = abp_q;
    res_en  = 1'b0;
    ld_en_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          base_d = {start_ptr_i[WORD_W-1:2], 2'b00};
          mst_d  = start_ptr_i[1:0];
          idx_d  = '0;
          abp_d  = 1'b0;
          st_d   = ST_FETCH;
        end
      end
      ST_FETCH: begin
        abp_d = stop_now;
        if (mem_ack_i) begin
          ld_en_o = 1'b1;
          if (stop_now) begin
            abp_d = 1'b0;
            st_d  = ST_IDLE;
          end else if (idx_q == LAST_FETCH_IDX) begin
            idx_d = '0;
            st_d  = ST_RUN;
          end else begin
            idx_d = idx_q + 3'd1;
          end
        end
      end
      ST_RUN: begin
        if (abort_i) begin
          st_d = ST_IDLE;
        end else if (blk_done_i) begin
          res_en = 1'b1;
          idx_d  = '0;
          st_d   = ST_WB;
        end
      end
      ST_WB: begin
        abp_d = stop_now;
        if (mem_ack_i) begin
          if (stop_now) begin
            abp_d = 1'b0;
            st_d  = ST_IDLE;
          end else if (idx_q == LAST_WB_IDX) begin
            idx_d = '0;
            if (follow) begin
              base_d = {next_i[WORD_W-1:2], 2'b00};
              mst_d  = next_i[1:0];
              st_d   = ST_FETCH;
            end else begin
              st_d = ST_IDLE;
            end
          end else begin
            idx_d = idx_q + 3'd1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      base_q <= '0;
      mst_q  <= '0;
      abp_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      base_q <= base_d;
      mst_q  <= mst_d;
      abp_q  <= abp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sstat_q <= '0;
      dstat_q <= '0;
    end else if (res_en) begin
      cnt_q   <= blk_count_i;
      sstat_q <= blk_sstat_i;
      dstat_q <= blk_dstat_i;
    end
  end

  assign st_o     = st_q;
  assign idx_o    = idx_q;
  assign base_o   = base_q;
  assign master_o = mst_q;
  assign cnt_o    = cnt_q;
  assign sstat_o  = sstat_q;
  assign dstat_o  = dstat_q;

  // R8
  abort_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_FETCH || st_q == ST_WB) && mem_ack_i && stop_now) |=> (st_q == ST_IDLE));

  // R9
  abort_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && abort_i) |=> (st_q == ST_IDLE));

  // R5
  done_to_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && blk_done_i && !abort_i) |=> (st_q == ST_WB && idx_q == 3'd0));

  // R6
  chain_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WB && mem_ack_i && !stop_now && idx_q == LAST_WB_IDX && follow)
      |=> (st_q == ST_FETCH && base_q == {$past(next_i[WORD_W-1:2]), 2'b00}));

  // R7
  chain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WB && mem_ack_i && !stop_now && idx_q == LAST_WB_IDX && next_i[WORD_W-1:2] == '0)
      |=> (st_q == ST_IDLE));
endmodule

// File: rtl/lw_port_mux.sv
module lw_port_mux
  import lw_pkg::*;
#(
  parameter int unsigned SIZE_W = 12
)(
  input  walk_st_e                 st_i,
  input  logic [2:0]               idx_i,
  input  logic [WORD_W-1:0]        base_i,
  input  logic [WORD_W-SIZE_W-2:0] ctl_hi_top_i,
  input  logic [SIZE_W-1:0]        cnt_i,
  input  logic [WORD_W-1:0]        sstat_i,
  input  logic [WORD_W-1:0]        dstat_i,
  output logic                     req_o,
  output logic                     we_o,
  output logic [WORD_W-1:0]        addr_o,
  output logic [WORD_W-1:0]        wdata_o
);
  logic [WORD_W-1:0] word_off;

  always_comb begin
    req_o    = (st_i == ST_FETCH) || (st_i == ST_WB);
    we_o     = (st_i == ST_WB);
    word_off = {{(WORD_W-5){1'b0}}, idx_i, 2'b00};
    if (st_i == ST_WB) begin
      word_off = word_off + WB_BYTE_OFF;
    end
    addr_o = base_i + word_off;
    unique case (idx_i)
      3'd0:    wdata_o = {ctl_hi_top_i, 1'b1, cnt_i};
      3'd1:    wdata_o = sstat_i;
      default: wdata_o = dstat_i;
    endcase
  end
endmodule

// File: rtl/ll_desc_walker.sv
module ll_desc_walker
  import lw_pkg::*;
#(
  parameter int unsigned SIZE_W = 12
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       start_ptr_i,
  input  logic              abort_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic [1:0]        mem_master_o,
  input  logic              mem_rsp_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              blk_valid_o,
  output logic [31:0]       blk_sar_o,
  output logic [31:0]       blk_dar_o,
  output logic [31:0]       blk_ctl_lo_o,
  output logic [SIZE_W-1:0] blk_size_o,
  input  logic              blk_done_i,
  input  logic [SIZE_W-1:0] blk_count_i,
  input  logic [31:0]       blk_sstat_i,
  input  logic [31:0]       blk_dstat_i,
  output logic [1:0]        st_state_o,
  output logic [31:0]       st_addr_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  walk_st_e          st;
  logic [2:0]        idx;
  logic [WORD_W-1:0] base;
  logic              ld_en;
  logic [SIZE_W-1:0] cnt;
  logic [WORD_W-1:0] sstat, dstat;
  logic [WORD_W-1:0] w_next, w_ctl_hi;
  logic              mem_ack;
  logic              chain_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_s_n = rst_sync_q[1];

  assign mem_ack  = mem_rsp_i && mem_req_o;
  assign chain_en = blk_ctl_lo_o[CL_SRC_CHAIN] | blk_ctl_lo_o[CL_DST_CHAIN];

  lw_ctrl #(.SIZE_W(SIZE_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .start_i     (start_i),
    .start_ptr_i (start_ptr_i),
    .abort_i     (abort_i),
    .mem_ack_i   (mem_ack),
    .blk_done_i  (blk_done_i),
    .blk_count_i (blk_count_i),
    .blk_sstat_i (blk_sstat_i),
    .blk_dstat_i (blk_dstat_i),
    .next_i      (w_next),
    .chain_en_i  (chain_en),
    .st_o        (st),
    .idx_o       (idx),
    .base_o      (base),
    .master_o    (mem_master_o),
    .ld_en_o     (ld_en),
    .cnt_o       (cnt),
    .sstat_o     (sstat),
    .dstat_o     (dstat)
  );

  lw_desc_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .ld_en_i   (ld_en),
    .ld_idx_i  (idx),
    .ld_data_i (mem_rdata_i),
    .src_o     (blk_sar_o),
    .dst_o     (blk_dar_o),
    .next_o    (w_next),
    .ctl_lo_o  (blk_ctl_lo_o),
    .ctl_hi_o  (w_ctl_hi)
  );

  lw_port_mux #(.SIZE_W(SIZE_W)) u_mux (
    .st_i         (st),
    .idx_i        (idx),
    .base_i       (base),
    .ctl_hi_top_i (w_ctl_hi[WORD_W-1:SIZE_W+1]),
    .cnt_i        (cnt),
    .sstat_i      (sstat),
    .dstat_i      (dstat),
    .req_o        (mem_req_o),
    .we_o         (mem_we_o),
    .addr_o       (mem_addr_o),
    .wdata_o      (mem_wdata_o)
  );

  logic unused_hi;
  assign unused_hi = ^w_ctl_hi[SIZE_W:SIZE_W];

  assign blk_valid_o = (st == ST_RUN);
  assign blk_size_o  = w_ctl_hi[SIZE_W-1:0];
  assign st_state_o  = st;
  assign st_addr_o   = base;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_req_o && !mem_rsp_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R4
  run_no_req_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    blk_valid_o |-> !mem_req_o);

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st != ST_IDLE && !(st == ST_WB && mem_ack)) |=> $stable(st_addr_o));
endmodule

// File: tb/sim_ll_desc_walker.sv
module sim_ll_desc_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] start_ptr_i;
  logic        abort_i;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [1:0]  mem_master_o;
  logic        mem_rsp_i;
  logic [31:0] mem_rdata_i;
  logic        blk_valid_o;
  logic [31:0] blk_sar_o, blk_dar_o, blk_ctl_lo_o;
  logic [11:0] blk_size_o;
  logic        blk_done_i;
  logic [11:0] blk_count_i;
  logic [31:0] blk_sstat_i, blk_dstat_i;
  logic [1:0]  st_state_o;
  logic [31:0] st_addr_o;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  int lat = 1;
  int wcnt = 0;
  bit saw_valid = 1'b0;
  logic [31:0] mem [int];

  always #2.5 clk = ~clk;

  ll_desc_walker u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_ptr_i(start_ptr_i), .abort_i(abort_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_master_o(mem_master_o), .mem_rsp_i(mem_rsp_i), .mem_rdata_i(mem_rdata_i),
    .blk_valid_o(blk_valid_o), .blk_sar_o(blk_sar_o), .blk_dar_o(blk_dar_o), .blk_ctl_lo_o(blk_ctl_lo_o),
    .blk_size_o(blk_size_o), .blk_done_i(blk_done_i), .blk_count_i(blk_count_i),
    .blk_sstat_i(blk_sstat_i), .blk_dstat_i(blk_dstat_i), .st_state_o(st_state_o), .st_addr_o(st_addr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 32'h0;
  endfunction

  // memory responder
  always @(posedge clk) begin
    if (mem_req_o && mem_rsp_i) begin
      if (mem_we_o) mem[int'(mem_addr_o)] = mem_wdata_o;
      wcnt = 0;
    end else if (mem_req_o) begin
      wcnt++;
    end else begin
      wcnt = 0;
    end
    #1;
    mem_rsp_i   = mem_req_o && (wcnt >= lat);
    mem_rdata_i = rd(mem_addr_o);
  end

  // behavioural reference model
  int          m_st;
  int          m_idx;
  logic [31:0] m_base;
  logic [1:0]  m_mst;
  bit          m_ab;
  logic [31:0] m_w [5];
  logic [11:0] m_cnt;
  logic [31:0] m_ss, m_ds;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_idx = 0; m_base = 0; m_mst = 0; m_ab = 0;
    end else begin
      bit ack;
      bit ab;
      ack = mem_req_o && mem_rsp_i;
      ab  = m_ab || abort_i;
      case (m_st)
        0: if (start_i) begin
             m_base = start_ptr_i & ~32'h3; m_mst = start_ptr_i[1:0];
             m_idx = 0; m_ab = 0; m_st = 1;
           end
        1: begin
             m_ab = ab;
             if (ack) begin
               m_w[m_idx] = mem_rdata_i;
               if (ab) begin m_ab = 0; m_st = 0; end
               else if (m_idx == 4) begin m_idx = 0; m_st = 2; end
               else m_idx++;
             end
           end
        2: if (abort_i) m_st = 0;
           else if (blk_done_i) begin
             m_cnt = blk_count_i; m_ss = blk_sstat_i; m_ds = blk_dstat_i;
             m_idx = 0; m_st = 3;
           end
        default: begin
             m_ab = ab;
             if (ack) begin
               if (ab) begin m_ab = 0; m_st = 0; end
               else if (m_idx == 2) begin
                 m_idx = 0;
                 if (((m_w[3] >> 27) & 32'h3) != 0 && (m_w[2] & ~32'h3) != 0) begin
                   m_base = m_w[2] & ~32'h3; m_mst = m_w[2][1:0]; m_st = 1;
                 end else m_st = 0;
               end else m_idx++;
             end
           end
      endcase
    end
  end

  function automatic logic [31:0] wb_word(input int i);
    if (i == 0) return (m_w[4] & 32'hFFFF_E000) | 32'h0000_1000 | {20'h0, m_cnt};
    if (i == 1) return m_ss;
    return m_ds;
  endfunction

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (blk_valid_o) saw_valid = 1'b1;
    if (cmp_on) begin
      chk("R10 state", {30'h0, st_state_o}, m_st);
      chk("R10 addr", st_addr_o, m_base);
      chk("R3 req", {31'h0, mem_req_o}, (m_st == 1 || m_st == 3) ? 1 : 0);
      if (m_st == 1) begin
        chk("R3 fetch addr", mem_addr_o, m_base + 4 * m_idx);
        chk("R3 read", {31'h0, mem_we_o}, 0);
      end
      if (m_st == 3) begin
        chk("R5 wb addr", mem_addr_o, m_base + 16 + 4 * m_idx);
        chk("R5 write", {31'h0, mem_we_o}, 1);
        chk("R5 wdata", mem_wdata_o, wb_word(m_idx));
      end
      if (m_st == 1 || m_st == 3) chk("R6 master", {30'h0, mem_master_o}, {30'h0, m_mst});
      chk("R4 valid", {31'h0, blk_valid_o}, (m_st == 2) ? 1 : 0);
      if (m_st == 2) begin
        chk("R4 sar", blk_sar_o, m_w[0]);
        chk("R4 dar", blk_dar_o, m_w[1]);
        chk("R4 ctl lo", blk_ctl_lo_o, m_w[3]);
        chk("R4 size", {20'h0, blk_size_o}, {20'h0, m_w[4][11:0]});
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_state(input logic [1:0] s);
    do tick(); while (st_state_o !== s);
  endtask

  task automatic begin_walk(input logic [31:0] ptr);
    start_i = 1'b1; start_ptr_i = ptr;
    tick();
    start_i = 1'b0; start_ptr_i = 32'h0;
  endtask

  task automatic finish_block(input logic [11:0] c, input logic [31:0] ss, input logic [31:0] ds);
    wait_state(2'd2);
    tick(); tick();
    blk_done_i = 1'b1; blk_count_i = c; blk_sstat_i = ss; blk_dstat_i = ds;
    tick();
    blk_done_i = 1'b0; blk_count_i = '0; blk_sstat_i = '0; blk_dstat_i = '0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] nx, input logic [31:0] cl, input logic [31:0] ch);
    mem[a] = s; mem[a+4] = d; mem[a+8] = nx; mem[a+12] = cl; mem[a+16] = ch;
    mem[a+20] = 32'hDEAD_0000; mem[a+24] = 32'hDEAD_0001;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 0; start_ptr_i = 0; abort_i = 0;
    blk_done_i = 0; blk_count_i = 0; blk_sstat_i = 0; blk_dstat_i = 0;
    mem_rsp_i = 0; mem_rdata_i = 0;
    put_desc(32'h100, 32'h1000, 32'h2000, 32'h201, 32'h1000_0001, 32'h0ABC_DE05);
    put_desc(32'h200, 32'h3000, 32'h4000, 32'h302, 32'h0000_0001, 32'h0000_0010);
    put_desc(32'h300, 32'h5000, 32'h6000, 32'h003, 32'h0800_0000, 32'hFFFF_F0FF);
    put_desc(32'h400, 32'h7000, 32'h8000, 32'h500, 32'h1800_0000, 32'h0000_0022);
    put_desc(32'h500, 32'h9000, 32'hA000, 32'h100, 32'h1800_0000, 32'h0000_0033);
    repeat (3) tick();
    // R1 reset state
    chk("R1 state", {30'h0, st_state_o}, 0);
    chk("R1 req", {31'h0, mem_req_o}, 0);
    chk("R1 valid", {31'h0, blk_valid_o}, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    cmp_on = 1'b1;

    // chain of two: first via source chaining, master from pointer bits; second has no chaining
    lat = 1;
    begin_walk(32'h101);
    wait_state(2'd2);
    begin_walk(32'h403);   // R2: busy start ignored
    chk("R2 busy start ignored", st_addr_o, 32'h100);
    finish_block(12'h123, 32'h55, 32'h66);
    finish_block(12'h007, 32'h77, 32'h88);
    wait_state(2'd0);
    chk("R5 ctl hi A", mem[32'h110], 32'h0ABC_D123);
    chk("R5 sstat A", mem[32'h114], 32'h55);
    chk("R5 dstat A", mem[32'h118], 32'h66);
    chk("R6 ctl hi B", mem[32'h210], 32'h0000_1007);
    chk("R6 chain stopped", mem[32'h310], 32'hFFFF_F0FF);

    // R7: destination chaining set but next address zero; zero latency memory
    lat = 0;
    begin_walk(32'h300);
    finish_block(12'hABC, 32'h1, 32'h2);
    wait_state(2'd0);
    chk("R7 ctl hi C", mem[32'h310], 32'hFFFF_FABC);
    chk("R7 ended idle", {30'h0, st_state_o}, 0);

    // R8: abort during fetch
    lat = 2;
    saw_valid = 1'b0;
    begin_walk(32'h400);
    repeat (4) tick();
    abort_i = 1'b1; tick(); abort_i = 1'b0;
    wait_state(2'd0);
    repeat (3) tick();
    chk("R8 no run", {31'h0, saw_valid}, 0);
    chk("R8 no write-back", mem[32'h410], 32'h0000_0022);
    chk("R8 no request", {31'h0, mem_req_o}, 0);

    // R9: abort while running
    lat = 1;
    begin_walk(32'h500);
    wait_state(2'd2);
    tick();
    abort_i = 1'b1; tick(); abort_i = 1'b0;
    chk("R9 idle", {30'h0, st_state_o}, 0);
    repeat (5) tick();
    chk("R9 no write-back", mem[32'h510], 32'h0000_0033);
    chk("R9 status kept", mem[32'h514], 32'hDEAD_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule